// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Timer

This block picks the moment a quasi-resonant flyback switch turns back on. When the primary switch turns off, the transformer first demagnetizes. Then the drain node rings, and the auxiliary-winding comparator toggles with each ring. The block waits out a short blanking window after turn-off. It then counts the ringing valleys, each seen as the comparator dropping low. When the count reaches the valley number given by an external selector, it emits a one-cycle turn-on pulse that sets the drive latch.

Heavily damped ringing may stop toggling the comparator. A timeout then stands in for the missing valleys: if the comparator stays low long enough, a substitute valley is produced and counted. At power-up no ringing exists at all, so the timeout by itself paces the turn-on pulses. This gives continuous-conduction cycles until real valleys appear. The blanking length depends on a light-load flag, which is captured when the switch turns off. All durations are cycle counts derived from a clock-frequency parameter.

Top module: `qr_valley_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `turn_on` and `valley_stb` are 0. After reset the block is hunting for valleys with its timeout timer at zero, and it treats the previous comparator value as low.
- R2: While hunting, a cycle in which `zcd_hi` is 0 after being 1 in the cycle before is a real valley. `valley_stb` is 1 for exactly the following cycle.
- R3: A `drv_off` pulse starts a blanking window during which the comparator is ignored. The window lasts for the `drv_off` cycle plus the next N cycles. N is 187 cycles when `light_load` is 0 and 100 cycles when it is 1 (defaults: 125 MHz, option 0; option 1 gives 125 and 75). `light_load` is sampled only in the `drv_off` cycle.
- R4: While hunting, a run of 812 consecutive cycles with `zcd_hi` = 0 is a substitute valley. The run is counted since the latest of: hunting start, the last valley, or the last cycle with `zcd_hi` = 1. A substitute valley also pulses `valley_stb`, and the next run starts from zero.
- R5: Real and substitute valleys advance one shared valley counter. Every `drv_off` clears it.
- R6: `turn_on` is 1 for one cycle, in the cycle after the valley that brings the count to `valley_sel`. A `valley_sel` of 0 acts as 1.
- R7: After `turn_on`, the comparator is ignored and no `valley_stb` occurs until the next `drv_off`.
- R8: With `zcd_hi` held at 0 and `valley_sel` = 1, `turn_on` follows 812 cycles after reset. After a `drv_off`, it follows blanking plus 812 cycles, which gives back-to-back cycles with no real valleys. With `valley_sel` = n, n timeouts are needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_off | input | 1 | One-cycle pulse: switch has just turned off |
| zcd_hi | input | 1 | Synchronized comparator: 1 above threshold, 0 below |
| light_load | input | 1 | 1 when the current reference is below a quarter of full scale |
| valley_sel | input | VW (3) | Valley number to turn on in; 0 acts as 1 |
| turn_on | output | 1 | One-cycle pulse that sets the drive latch |
| valley_stb | output | 1 | One-cycle pulse for each counted valley, real or substitute |

## Verification
The bench places a falling comparator edge exactly on the last blanked cycle and on the first hunting cycle. A blanking window that is off by one, or that uses the wrong load flag, moves turn-on by a whole timeout. Runs with the comparator stuck low, at reset and after turn-off, expose a timeout that does not restart or does not count toward the target. A design with that fault would never reach valley seven, or would reach it one timeout early or late. Mixed real-then-substitute sequences, a zero selector and continued ringing after turn-on catch a split counter, a missing zero-as-one rule and valleys leaking past turn-on.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_BLANK = 2'd1,
        ST_ON    = 2'd2
    } qrv_state_e;

    typedef struct packed {
        logic fall;
        logic tmo;
    } qrv_valley_s;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz) / 1000;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/qrv_blanker.sv
module qrv_blanker #(
    parameter int unsigned NORM_CYC = 187,
    parameter int unsigned LITE_CYC = 100,
    parameter int unsigned W        = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic light,
    output logic done
);
    logic [W-1:0] len_q;
    logic [W-1:0] cnt_q;

    assign done = active && (cnt_q == len_q - W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= W'(NORM_CYC);
            cnt_q <= '0;
        end else if (start) begin
            len_q <= light ? W'(LITE_CYC) : W'(NORM_CYC);
            cnt_q <= '0;
        end else if (active && !done) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/qrv_zcd_timer.sv
module qrv_zcd_timer
    import qrv_pkg::*;
#(
    parameter int unsigned TMO_CYC = 812,
    parameter int unsigned TW      = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp,
    input  logic          hunt,
    output qrv_valley_s   valley,
    output logic [TW-1:0] tmr
);
    logic          prev_q;
    logic [TW-1:0] tmr_q;

    // falling edge of the comparator while hunting
    assign valley.fall = hunt && prev_q && !cmp;
    // comparator held low for the full timeout window
    assign valley.tmo  = hunt && !cmp && !prev_q && (tmr_q == TW'(TMO_CYC - 1));
    assign tmr         = tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            tmr_q  <= '0;
        end else begin
            prev_q <= cmp;
            if (!hunt || cmp || valley.fall || valley.tmo)
                tmr_q <= '0;
            else
                tmr_q <= tmr_q + TW'(1);
        end
    end
endmodule

// File: rtl/qrv_vcount.sv
module qrv_vcount #(
    parameter int unsigned VW = 3,
    parameter int unsigned CW = VW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          inc,
    input  logic [VW-1:0] sel,
    output logic          hit,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] tgt;

    assign tgt = (sel == '0) ? CW'(1) : CW'(sel);
    assign hit = inc && ((cnt_q + CW'(1)) >= tgt);
    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (inc && (cnt_q != '1))
            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/qr_valley_timer.sv
module qr_valley_timer
    import qrv_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 125,
    parameter int unsigned BLANK_OPT = 0,
    parameter int unsigned TMO_NS    = 6500,
    parameter int unsigned VW        = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          drv_off,
    input  logic          zcd_hi,
    input  logic          light_load,
    input  logic [VW-1:0] valley_sel,
    output logic          turn_on,
    output logic          valley_stb
);
    localparam int unsigned BL_NORM_NS = (BLANK_OPT != 0) ? 1000 : 1500;
    localparam int unsigned BL_LITE_NS = (BLANK_OPT != 0) ? 600 : 800;
    localparam int unsigned BL_N_CYC   = ns_to_cyc(BL_NORM_NS, CLK_MHZ);
    localparam int unsigned BL_L_CYC   = ns_to_cyc(BL_LITE_NS, CLK_MHZ);
    localparam int unsigned TMO_CYC    = ns_to_cyc(TMO_NS, CLK_MHZ);
    localparam int unsigned BW         = width_for(BL_N_CYC > BL_L_CYC ? BL_N_CYC : BL_L_CYC);
    localparam int unsigned TW         = width_for(TMO_CYC);
    localparam int unsigned CW         = VW + 1;

    qrv_state_e    state_q, state_d;
    qrv_valley_s   vly;
    logic          hunt, blank_done, valley_any, hit;
    logic [CW-1:0] vcnt;
    logic [TW-1:0] tmr;
    logic          turn_on_q, valley_stb_q;

    assign hunt       = (state_q == ST_HUNT);
    assign valley_any = (vly.fall || vly.tmo) && !drv_off;

    qrv_blanker #(.NORM_CYC(BL_N_CYC), .LITE_CYC(BL_L_CYC), .W(BW)) u_blank (
        .clk    (clk),
        .rst    (rst),
        .start  (drv_off),
        .active (state_q == ST_BLANK),
        .light  (light_load),
        .done   (blank_done)
    );

    qrv_zcd_timer #(.TMO_CYC(TMO_CYC), .TW(TW)) u_zcd (
        .clk    (clk),
        .rst    (rst),
        .cmp    (zcd_hi),
        .hunt   (hunt),
        .valley (vly),
        .tmr    (tmr)
    );

    qrv_vcount #(.VW(VW), .CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (drv_off),
        .inc   (valley_any),
        .sel   (valley_sel),
        .hit   (hit),
        .cnt   (vcnt)
    );

    always_comb begin
        state_d = state_q;
        if (drv_off)
            state_d = ST_BLANK;
        else begin
            case (state_q)
                ST_BLANK: if (blank_done) state_d = ST_HUNT;
                ST_HUNT:  if (hit)        state_d = ST_ON;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_HUNT;
            turn_on_q    <= 1'b0;
            valley_stb_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            turn_on_q    <= hit;
            valley_stb_q <= valley_any;
        end
    end

    assign turn_on    = turn_on_q;
    assign valley_stb = valley_stb_q;
endmodule

// File: rtl/qr_valley_timer_chk.sv
module qr_valley_timer_chk
    import qrv_pkg::*;
#(
    parameter int unsigned CW        = 4,
    parameter int unsigned TW        = 10,
    parameter int unsigned TMO       = 812,
    parameter int unsigned BLANK_MIN = 100
) (
    input logic          clk,
    input logic          rst,
    input logic          drv_off,
    input logic          turn_on,
    input logic          valley_stb,
    input qrv_state_e    state,
    input logic [CW-1:0] vcnt,
    input logic [TW-1:0] tmr
);
    logic [15:0] since_off;

    always_ff @(posedge clk) begin
        if (rst)
            since_off <= '1;
        else if (drv_off)
            since_off <= '0;
        else if (since_off != '1)
            since_off <= since_off + 16'd1;
    end

    p_stb_from_hunt_r2: assert property (@(posedge clk) disable iff (rst)
        valley_stb |-> $past(state) == ST_HUNT);

    p_blank_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        valley_stb |-> since_off > 16'(BLANK_MIN));

    p_timer_bound_r4: assert property (@(posedge clk) disable iff (rst)
        tmr < TW'(TMO));

    p_off_clears_r5: assert property (@(posedge clk) disable iff (rst)
        drv_off |=> vcnt == '0);

    p_on_with_stb_r6: assert property (@(posedge clk) disable iff (rst)
        turn_on |-> valley_stb && vcnt != '0);

    p_quiet_after_on_r7: assert property (@(posedge clk) disable iff (rst)
        turn_on |=> !turn_on && !valley_stb);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !turn_on && !valley_stb);
endmodule

bind qr_valley_timer qr_valley_timer_chk #(
    .CW(CW), .TW(TW), .TMO(TMO_CYC), .BLANK_MIN(BL_L_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .drv_off    (drv_off),
    .turn_on    (turn_on),
    .valley_stb (valley_stb),
    .state      (state_q),
    .vcnt       (vcnt),
    .tmr        (tmr)
);

// File: tb/qr_valley_timer_tb.sv
module qr_valley_timer_tb;
    localparam int VW   = 3;
    localparam int TMO  = 812;
    localparam int BL_N = 187;
    localparam int BL_L = 100;
    localparam int MAXN = 6600;

    logic clk = 1'b0;
    logic rst, drv_off, zcd_hi, light_load;
    logic [VW-1:0] valley_sel;
    logic turn_on, valley_stb;

    int checks = 0;
    int errors = 0;

    bit wave    [MAXN];
    bit light_w [MAXN];
    int cause   [MAXN];
    bit eon     [MAXN];

    always #4 clk = ~clk;

    qr_valley_timer u_dut (
        .clk(clk), .rst(rst), .drv_off(drv_off), .zcd_hi(zcd_hi),
        .light_load(light_load), .valley_sel(valley_sel),
        .turn_on(turn_on), .valley_stb(valley_stb)
    );

    function automatic string tag_for(int j, int len, int on_j);
        if (cause[j] == 2) return "R2";
        if (cause[j] == 4) return "R4";
        if (j <= len) return "R3";
        if (on_j >= 0 && j > on_j) return "R7";
        return "R5";
    endfunction

    // Expected-value model built from the requirements
    task automatic model(input bit do_off, input int len, input int sel_v, output int on_j);
        int timer = 0;
        int cnt = 0;
        int tgt = (sel_v == 0) ? 1 : sel_v;
        bit prev = 1'b0;
        on_j = -1;
        for (int j = 0; j < MAXN; j++) begin cause[j] = 0; eon[j] = 1'b0; end
        for (int j = (do_off ? 0 : 1); j < MAXN; j++) begin
            if (on_j >= 0) break;
            if ((do_off && j == 0) || j <= len) begin prev = wave[j]; continue; end
            if (wave[j]) timer = 0;
            else if (prev) begin cause[j] = 2; timer = 0; end
            else if (timer == TMO - 1) begin cause[j] = 4; timer = 0; end
            else timer++;
            prev = wave[j];
            if (cause[j] != 0) begin
                cnt++;
                if (cnt >= tgt) begin eon[j] = 1'b1; on_j = j; end
            end
        end
    endtask

    task automatic run_case(input bit do_off, input int sel_v, input int exp_idx, input string tag);
        int len = do_off ? (light_w[0] ? BL_L : BL_N) : 0;
        int on_j;
        int seen = -1;
        int last;
        model(do_off, len, sel_v, on_j);
        last = (on_j < 0) ? MAXN - 1 : ((on_j + 30 < MAXN) ? on_j + 30 : MAXN - 1);
        valley_sel = VW'(sel_v);
        for (int j = (do_off ? 0 : 1); j <= last; j++) begin
            drv_off    = do_off && (j == 0);
            zcd_hi     = wave[j];
            light_load = light_w[j];
            @(negedge clk);
            if (cause[j] != 0 || valley_stb) begin
                checks++;
                if (valley_stb !== (cause[j] != 0)) begin
                    errors++;
                    $display("FAIL %s %s edge %0d valley_stb act %0b exp %0b",
                             tag_for(j, len, on_j), tag, j, valley_stb, cause[j] != 0);
                end
            end
            if (eon[j] || turn_on) begin
                checks++;
                if (turn_on && seen < 0) seen = j;
                if (turn_on !== eon[j]) begin
                    errors++;
                    $display("FAIL %s %s edge %0d turn_on act %0b exp %0b",
                             (on_j >= 0 && j > on_j) ? "R7" : "R6", tag, j, turn_on, eon[j]);
                end
            end
        end
        drv_off = 1'b0;
        checks++;   // R6: turn-on lands on the model's edge
        if (seen != on_j) begin
            errors++;
            $display("FAIL R6 %s turn_on edge act %0d exp %0d", tag, seen, on_j);
        end
        if (exp_idx >= 0) begin
            checks++;   // directed edge index computed by hand
            if (seen != exp_idx) begin
                errors++;
                $display("FAIL %s turn_on edge act %0d exp %0d", tag, seen, exp_idx);
            end
        end
        zcd_hi = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic fill(input int hi_to, input bit lt0, input bit lt_rest);
        for (int j = 0; j < MAXN; j++) begin
            wave[j] = (j <= hi_to);
            light_w[j] = (j == 0) ? lt0 : lt_rest;
        end
    endtask

    initial begin
        #(8 * 190000);
        checks++;
        errors++;
        $display("FAIL R6 watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20517));
        rst = 1'b1; drv_off = 1'b0; zcd_hi = 1'b0; light_load = 1'b0; valley_sel = VW'(1);
        repeat (4) @(negedge clk);
        checks++;   // R1: quiet during reset
        if (turn_on !== 1'b0 || valley_stb !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs act %0b%0b exp 00", turn_on, valley_stb);
        end
        rst = 1'b0;
        // R8 startup: timeout alone paces turn-on (R1 timer starts from zero)
        fill(-1, 1'b0, 1'b0);
        run_case(1'b0, 1, TMO, "R8 startup");
        // R8 CCM after turn-off, comparator stuck low
        fill(-1, 1'b0, 1'b0);
        run_case(1'b1, 1, BL_N + TMO, "R8 ccm");
        // R3 light blank: fall on last blanked edge ignored, R6 sel zero acts as one
        fill(99, 1'b1, 1'b0);
        for (int j = 110; j < 120; j++) wave[j] = 1'b1;
        run_case(1'b1, 0, 120, "R3 light edge");
        // R3 normal blank boundary: fall on last blanked edge ignored
        fill(186, 1'b0, 1'b1);
        run_case(1'b1, 1, BL_N + 1 + TMO - 1, "R3 last blanked");
        // R3 fall on first hunting edge counted
        fill(187, 1'b0, 1'b1);
        run_case(1'b1, 1, BL_N + 1, "R3 first hunt");
        // R5 two real valleys then a substitute
        fill(199, 1'b0, 1'b0);
        for (int j = 210; j < 220; j++) wave[j] = 1'b1;
        run_case(1'b1, 3, 220 + TMO, "R5 mixed");
        // R4 seven substitutes in a row
        fill(-1, 1'b1, 1'b1);
        run_case(1'b1, 7, BL_L + 1 + TMO - 1 + 6 * TMO, "R4 seven");
        // random ringing
        for (int n = 0; n < 18; n++) begin
            int p = $urandom_range(400, 50);
            int rings = $urandom_range(6, 0);
            for (int j = 0; j < MAXN; j++) begin
                wave[j] = 1'b0;
                light_w[j] = bit'($urandom_range(1, 0));
            end
            for (int j = 0; j < p; j++) wave[j] = 1'b1;
            for (int r = 0; r < rings; r++) begin
                p += $urandom_range(80, 5);
                for (int k = $urandom_range(80, 5); k > 0 && p < MAXN; k--) begin
                    wave[p] = 1'b1; p++;
                end
            end
            run_case(1'b1, $urandom_range(7, 0), -1, "random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule